// File: doc/BRIEF.md
# CAN Message and Status Interrupt Controller

This block forms the single interrupt request of a CAN controller from two kinds of source. The first kind is the completion of a frame in one of fifteen message centers. Each center keeps its own receive-enable and transmit-enable bits, written through a small configuration port. It also keeps a request flag that sets when a completion matches an enabled direction. The flag stays set until software clears it. A priority encoder reports the lowest-numbered requesting center, so the service routine knows where to look.

The second kind is a change in the controller status register. Status changes fall into two groups, and each group has its own enable. The first group covers receive success, transmit success, wake and a change of the error code. The second group covers bus-off and the error-count threshold. Each group holds a pending latch that a status-register read clears. Any number of changes before that read fold into one interrupt. A change that arrives after the read raises a new one, even if software has not yet cleared the success bit.

The frame engine and the status-bit producers lie outside the block and reach it as one-cycle strobes. The final request is the OR of all sources, qualified by a source enable, a mask bit and a global enable. The request is registered.

Top module: `can_irq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq`, `irq_id`, `ctr_req`, `grp_a_pend` and `grp_b_pend` are all zero, and every receive and transmit enable is cleared.
- R2: Bit i of `rx_ok`, `tx_ok`, `clr_req` and `ctr_req` belongs to center i+1. A write with `cfg_we` and `cfg_idx` = k in 1..15 loads the enables of center k; `cfg_idx` = 0 writes nothing. Flag k sets at the clock edge after a receive strobe only if its receive enable is set, and after a transmit strobe only if its transmit enable is set.
- R3: A set flag stays set until its `clr_req` bit is strobed. A completion and a clear in the same cycle leave the flag set.
- R4: `irq_id` gives the number (1 to 15) of the lowest-numbered set flag, or 0 when no flag is set. It trails `ctr_req` by one clock.
- R5: A strobe on any of `sts_rxs_chg`, `sts_txs_chg`, `sts_wake_chg` or `sts_ecode_chg` sets `grp_a_pend` at the next edge when `stat_ie` is 1. When `stat_ie` is 0 the strobe is ignored.
- R6: A strobe on `sts_busoff_chg` or `sts_ewarn_chg` sets `grp_b_pend` at the next edge when `err_ie` is 1. When `err_ie` is 0 the strobe is ignored.
- R7: A `stat_rd` strobe clears both group latches at the next edge. Several changes before that read leave a single pending state, and one read removes it.
- R8: A success change that arrives after a status read sets the group latch again.
- R9: `irq` equals, one clock later, (any flag OR `grp_a_pend` OR `grp_b_pend`) AND `src_en` AND `mask_en` AND `glb_en`.
- R10: A group change and a `stat_rd` in the same cycle leave that group pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for a center's enables |
| cfg_idx | input | 4 | Center number 1..15 to write; 0 writes nothing |
| cfg_rx_en | input | 1 | Receive-interrupt enable value |
| cfg_tx_en | input | 1 | Transmit-interrupt enable value |
| rx_ok | input | 15 | Successful-receive strobe per center |
| tx_ok | input | 15 | Successful-transmit strobe per center |
| clr_req | input | 15 | Software clear of the request flags |
| sts_rxs_chg | input | 1 | Receive-success status change |
| sts_txs_chg | input | 1 | Transmit-success status change |
| sts_wake_chg | input | 1 | Wake status change |
| sts_ecode_chg | input | 1 | Error-code status change |
| sts_busoff_chg | input | 1 | Bus-off status change |
| sts_ewarn_chg | input | 1 | Error-count threshold status change |
| stat_rd | input | 1 | Status-register read strobe |
| stat_ie | input | 1 | Enable for the first status group |
| err_ie | input | 1 | Enable for the second status group |
| src_en | input | 1 | Enable for this interrupt source |
| mask_en | input | 1 | Mask bit, 1 lets the request pass |
| glb_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | 4 | Lowest requesting center, 0 if none |
| ctr_req | output | 15 | Request flags of the centers |
| grp_a_pend | output | 1 | First status group pending |
| grp_b_pend | output | 1 | Second status group pending |

## Verification
Suppose a flag or an enable bit goes wrong inside the block. The fault shows up on `ctr_req` at the edge after the completion strobe. It then reaches `irq_id` and `irq` one edge later, so the bench compares every output in every cycle against a model built from the requirements. A latch that misses a read, or one that clears on the same cycle as a new change, changes `grp_a_pend` or `grp_b_pend` within one clock. Such a latch also holds `irq` at the wrong level from the following clock onward. The stimulus puts receive, transmit, clear, read and change strobes into the same cycle on purpose, so that a wrong set/clear priority becomes visible.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  // widths of the two status-change groups
  localparam int unsigned GA_W = 4;
  localparam int unsigned GB_W = 2;

  function automatic int unsigned id_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/can_irq_msgbank.sv
module can_irq_msgbank #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_rx_en,
  input  logic          cfg_tx_en,
  input  logic [N-1:0]  rx_ok,
  input  logic [N-1:0]  tx_ok,
  input  logic [N-1:0]  clr_req,
  output logic [N-1:0]  req
);
  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic rxe_q, txe_q, req_q;
    logic hit;

    // a completion counts only in an enabled direction
    assign hit = (rx_ok[g] && rxe_q) || (tx_ok[g] && txe_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        rxe_q <= 1'b0;
        txe_q <= 1'b0;
        req_q <= 1'b0;
      end else begin
        if (cfg_we && cfg_idx == IW'(g + 1)) begin
          rxe_q <= cfg_rx_en;
          txe_q <= cfg_tx_en;
        end
        if (hit)
          req_q <= 1'b1;        // set beats clear
        else if (clr_req[g])
          req_q <= 1'b0;
      end
    end

    assign req[g] = req_q;
  end
endmodule

// File: rtl/can_irq_grp.sv
module can_irq_grp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         en,
  input  logic         rd,
  output logic         pend
);
  logic set_now;
  assign set_now = en && (|evt);

  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (set_now)
      pend <= 1'b1;             // a change during a read stays pending
    else if (rd)
      pend <= 1'b0;
  end
endmodule

// File: rtl/can_irq_prienc.sv
module can_irq_prienc #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i + 1);
    end
  end
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter  int NUM_CTR = 15,
  localparam int ID_W    = $clog2(NUM_CTR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ID_W-1:0]    cfg_idx,
  input  logic               cfg_rx_en,
  input  logic               cfg_tx_en,
  input  logic [NUM_CTR-1:0] rx_ok,
  input  logic [NUM_CTR-1:0] tx_ok,
  input  logic [NUM_CTR-1:0] clr_req,
  input  logic               sts_rxs_chg,
  input  logic               sts_txs_chg,
  input  logic               sts_wake_chg,
  input  logic               sts_ecode_chg,
  input  logic               sts_busoff_chg,
  input  logic               sts_ewarn_chg,
  input  logic               stat_rd,
  input  logic               stat_ie,
  input  logic               err_ie,
  input  logic               src_en,
  input  logic               mask_en,
  input  logic               glb_en,
  output logic               irq,
  output logic [ID_W-1:0]    irq_id,
  output logic [NUM_CTR-1:0] ctr_req,
  output logic               grp_a_pend,
  output logic               grp_b_pend
);
  logic [GA_W-1:0] ga_evt;
  logic [GB_W-1:0] gb_evt;
  logic [ID_W-1:0] id_d;
  logic            irq_d;

  assign ga_evt = {sts_ecode_chg, sts_wake_chg, sts_txs_chg, sts_rxs_chg};
  assign gb_evt = {sts_ewarn_chg, sts_busoff_chg};

  can_irq_msgbank #(.N(NUM_CTR), .IW(ID_W)) bank_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
    .rx_ok(rx_ok), .tx_ok(tx_ok), .clr_req(clr_req),
    .req(ctr_req)
  );

  can_irq_grp #(.W(GA_W)) grp_a_i (
    .clk(clk), .rst(rst), .evt(ga_evt), .en(stat_ie), .rd(stat_rd),
    .pend(grp_a_pend)
  );

  can_irq_grp #(.W(GB_W)) grp_b_i (
    .clk(clk), .rst(rst), .evt(gb_evt), .en(err_ie), .rd(stat_rd),
    .pend(grp_b_pend)
  );

  can_irq_prienc #(.N(NUM_CTR), .IW(ID_W)) enc_i (
    .vec(ctr_req), .idx(id_d)
  );

  assign irq_d = ((|ctr_req) || grp_a_pend || grp_b_pend)
                 && src_en && mask_en && glb_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      irq_id <= '0;
    end else begin
      irq    <= irq_d;
      irq_id <= id_d;
    end
  end
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  rx_ok,
  input logic [N-1:0]  tx_ok,
  input logic [N-1:0]  clr_req,
  input logic          sts_rxs_chg,
  input logic          sts_txs_chg,
  input logic          sts_wake_chg,
  input logic          sts_ecode_chg,
  input logic          stat_rd,
  input logic          stat_ie,
  input logic          src_en,
  input logic          mask_en,
  input logic          glb_en,
  input logic          irq,
  input logic [IW-1:0] irq_id,
  input logic [N-1:0]  ctr_req,
  input logic          grp_a_pend,
  input logic          grp_b_pend
);
  logic [N-1:0] prev_req;
  logic         ga_any;

  assign ga_any = sts_rxs_chg || sts_txs_chg || sts_wake_chg || sts_ecode_chg;

  always_ff @(posedge clk) begin
    if (rst) prev_req <= '0;
    else     prev_req <= ctr_req;
  end

  for (genvar g = 0; g < N; g++) begin : g_flag
    AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
      (ctr_req[g] && !$past(ctr_req[g])) |-> $past(rx_ok[g] || tx_ok[g])); // R2
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
      (ctr_req[g] && !clr_req[g]) |=> ctr_req[g]); // R3
  end

  AST_ID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (irq_id == '0) |-> (prev_req == '0)); // R4
  AST_ID_SET: assert property (@(posedge clk) disable iff (rst)
    (irq_id != '0) |-> prev_req[irq_id - 1'b1]); // R4
  AST_ID_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (irq_id != '0) |-> ((prev_req & ((N'(1) << (irq_id - 1'b1)) - N'(1))) == '0)); // R4
  AST_GA_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!stat_ie && !grp_a_pend) |=> !grp_a_pend); // R5
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ga_any) |=> !grp_a_pend); // R7
  AST_RD_EVT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && stat_ie && ga_any) |=> grp_a_pend); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(src_en && mask_en && glb_en)); // R9
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((|ctr_req) || grp_a_pend || grp_b_pend)); // R9
endmodule

bind can_irq_ctrl can_irq_chk #(.N(NUM_CTR), .IW(ID_W)) chk_i (.*);

// File: tb/can_irq_ctrl_tb_top.sv
module can_irq_ctrl_tb_top;
  localparam int N = 15;

  typedef struct {
    logic         irq;
    logic [3:0]   id;
    logic [N-1:0] flg;
    logic         pa;
    logic         pb;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_rx_en = 1'b0, cfg_tx_en = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [N-1:0] rx_ok = '0, tx_ok = '0, clr_req = '0;
  logic s_rxs = 1'b0, s_txs = 1'b0, s_wake = 1'b0, s_ec = 1'b0, s_bo = 1'b0, s_ew = 1'b0;
  logic stat_rd = 1'b0, stat_ie = 1'b0, err_ie = 1'b0;
  logic src_en = 1'b1, mask_en = 1'b1, glb_en = 1'b1;
  logic irq;
  logic [3:0] irq_id;
  logic [N-1:0] ctr_req;
  logic grp_a_pend, grp_b_pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  // reference state
  logic [N-1:0] m_rxe = '0, m_txe = '0, m_flg = '0;
  logic m_pa = 1'b0, m_pb = 1'b0, m_irq = 1'b0;
  logic [3:0] m_id = '0;

  always #5 clk = ~clk;

  can_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
    .rx_ok(rx_ok), .tx_ok(tx_ok), .clr_req(clr_req),
    .sts_rxs_chg(s_rxs), .sts_txs_chg(s_txs), .sts_wake_chg(s_wake),
    .sts_ecode_chg(s_ec), .sts_busoff_chg(s_bo), .sts_ewarn_chg(s_ew),
    .stat_rd(stat_rd), .stat_ie(stat_ie), .err_ie(err_ie),
    .src_en(src_en), .mask_en(mask_en), .glb_en(glb_en),
    .irq(irq), .irq_id(irq_id), .ctr_req(ctr_req),
    .grp_a_pend(grp_a_pend), .grp_b_pend(grp_b_pend)
  );

  function automatic logic [3:0] lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  // driver: one clock with the current inputs, model update, push expectation
  task automatic tick(input string tag);
    exp_t e;
    @(posedge clk);
    if (rst) begin
      m_rxe = '0; m_txe = '0; m_flg = '0; m_pa = 0; m_pb = 0; m_irq = 0; m_id = '0;
    end else begin
      m_irq = ((|m_flg) || m_pa || m_pb) && src_en && mask_en && glb_en;
      m_id  = lowest(m_flg);
      for (int i = 0; i < N; i++) begin
        if ((rx_ok[i] && m_rxe[i]) || (tx_ok[i] && m_txe[i])) m_flg[i] = 1'b1;
        else if (clr_req[i]) m_flg[i] = 1'b0;
      end
      if (cfg_we && cfg_idx >= 1 && cfg_idx <= N) begin
        m_rxe[cfg_idx - 1] = cfg_rx_en;
        m_txe[cfg_idx - 1] = cfg_tx_en;
      end
      if (stat_ie && (s_rxs || s_txs || s_wake || s_ec)) m_pa = 1'b1;
      else if (stat_rd) m_pa = 1'b0;
      if (err_ie && (s_bo || s_ew)) m_pb = 1'b1;
      else if (stat_rd) m_pb = 1'b0;
    end
    e.irq = m_irq; e.id = m_id; e.flg = m_flg; e.pa = m_pa; e.pb = m_pb; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    cfg_we = 0; rx_ok = '0; tx_ok = '0; clr_req = '0;
    s_rxs = 0; s_txs = 0; s_wake = 0; s_ec = 0; s_bo = 0; s_ew = 0; stat_rd = 0;
  endtask

  task automatic cfg(input int k, input logic rxe, input logic txe, input string tag);
    cfg_we = 1; cfg_idx = 4'(k); cfg_rx_en = rxe; cfg_tx_en = txe;
    tick(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor: pops and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks += 5;
        if (irq !== e.irq) begin fails++;
          $display("FAIL %s irq act=%0b exp=%0b", e.tag, irq, e.irq); end
        if (irq_id !== e.id) begin fails++;
          $display("FAIL %s irq_id act=%0d exp=%0d", e.tag, irq_id, e.id); end
        if (ctr_req !== e.flg) begin fails++;
          $display("FAIL %s ctr_req act=%h exp=%h", e.tag, ctr_req, e.flg); end
        if (grp_a_pend !== e.pa) begin fails++;
          $display("FAIL %s grp_a_pend act=%0b exp=%0b", e.tag, grp_a_pend, e.pa); end
        if (grp_b_pend !== e.pb) begin fails++;
          $display("FAIL %s grp_b_pend act=%0b exp=%0b", e.tag, grp_b_pend, e.pb); end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3, "R1");
    rst = 0;
    idle(2, "R1");
    // R2: strobes without enables do nothing; index 0 writes nothing
    rx_ok[2] = 1; tx_ok[4] = 1; tick("R2");
    cfg(0, 1, 1, "R2");
    rx_ok = '1; tick("R2");
    cfg(3, 1, 0, "R2");
    cfg(5, 0, 1, "R2");
    tx_ok[2] = 1; rx_ok[4] = 1; tick("R2");
    idle(2, "R2");
    rx_ok[2] = 1; tick("R2");
    tx_ok[4] = 1; tick("R2");
    idle(2, "R4");
    // R3: clear together with completion keeps the flag
    rx_ok[2] = 1; clr_req[2] = 1; tick("R3");
    idle(2, "R3");
    clr_req[2] = 1; tick("R3");
    idle(2, "R4");
    // R4: extreme centers
    cfg(1, 1, 1, "R4");
    cfg(15, 1, 1, "R4");
    tx_ok[14] = 1; tick("R4");
    idle(2, "R4");
    rx_ok[0] = 1; tick("R4");
    idle(2, "R4");
    clr_req[0] = 1; clr_req[4] = 1; tick("R4");
    idle(2, "R4");
    // R9: each qualifier gates the request
    glb_en = 0; idle(2, "R9");
    glb_en = 1; mask_en = 0; idle(2, "R9");
    mask_en = 1; src_en = 0; idle(2, "R9");
    src_en = 1; idle(2, "R9");
    clr_req = '1; tick("R9");
    idle(2, "R9");
    // R5: group A ignored while disabled, then latched
    s_rxs = 1; s_wake = 1; s_ec = 1; s_txs = 1; tick("R5");
    idle(2, "R5");
    stat_ie = 1;
    s_wake = 1; tick("R5");
    s_ec = 1; tick("R5");
    s_txs = 1; tick("R5");
    idle(2, "R5");
    // R7: one read removes folded changes
    stat_rd = 1; tick("R7");
    idle(3, "R7");
    // R8: success after the read raises again
    s_rxs = 1; tick("R8");
    idle(2, "R8");
    // R10: change and read together stay pending
    s_txs = 1; stat_rd = 1; tick("R10");
    idle(2, "R10");
    stat_rd = 1; tick("R7");
    idle(2, "R7");
    // R6: group B
    s_bo = 1; tick("R6");
    idle(2, "R6");
    err_ie = 1;
    s_ew = 1; tick("R6");
    s_bo = 1; tick("R6");
    idle(2, "R6");
    stat_rd = 1; tick("R7");
    idle(2, "R7");
    s_ew = 1; stat_rd = 1; tick("R10");
    idle(2, "R10");
    stat_rd = 1; tick("R7");
    idle(3, "R7");
    done = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule